// File: doc/BRIEF.md
# Read Prefetch Length Controller

This block sits beside the read engine of a conventional-to-conventional bridge path and decides how many bytes a memory read request may prefetch. For each request it looks at the command type, whether the target region is prefetchable, the cache line size and a buffering control word. It returns a registered byte limit for the read engine one cycle later.

Each of the three read commands has its own 2-bit policy field in the control word. Full prefetch is capped by a 3-bit maximum byte count field. Cache-line policies are measured from the start address to the end of its line, so an unaligned start fetches fewer bytes.

While the engine moves data, the block tracks the current doubleword address. It raises a stop strobe while the transferred doubleword is the last one below a 1 MB boundary. This forces a disconnect before the fetch crosses that boundary.

Top module: `pf_len_ctrl`

## Requirements
- R1: A plain memory read (`req_cmd` = 2'b00) with `req_pref` = 0 yields 4 bytes, whatever the control word holds. `req_pref` has no effect on the other commands.
- R2: The policy field is chosen by the command. Plain memory read uses `buf_ctrl[9:8]`, memory read line (2'b01) uses `buf_ctrl[7:6]`, and memory read multiple (2'b10) uses `buf_ctrl[5:4]`. The reserved command 2'b11 always yields 4 bytes.
- R3: Policy encoding. 2'b00 gives 4 bytes. 2'b01 gives the bytes from the start doubleword to the end of its cache line. 2'b10 gives that amount plus one further line.
- R4: Policy 2'b11 gives the maximum byte count: 512 << n bytes for n = `buf_ctrl[14:12]` in 0..3, and 512 bytes for n from 4 to 7.
- R5: The line size is `line_dw` doublewords and must be a power of two. A value of 0 is treated as one doubleword. `req_addr[1:0]` does not affect the length.
- R6: `len_valid` is high for exactly the one cycle after each cycle with `req_valid` high, and `len_bytes` then holds that request's limit.
- R7: `bound_stop` is high while the doubleword being transferred has address bits 19:2 all ones. At that point the next doubleword would start a new 1 MB region.
- R8: A request starts tracking at its start doubleword. Each `dw_ack` advances one doubleword. Tracking ends when the strobed doubleword is acknowledged or when the byte limit is used up, and `bound_stop` stays low until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New read request this cycle |
| req_cmd | input | 2 | Read command: 00 plain, 01 line, 10 multiple, 11 reserved |
| req_addr | input | 32 | Start byte address |
| req_pref | input | 1 | Target region is prefetchable |
| line_dw | input | 8 | Cache line size in doublewords |
| buf_ctrl | input | 16 | Buffering control word (policy and max-count fields) |
| dw_ack | input | 1 | One doubleword transferred this cycle |
| len_valid | output | 1 | Byte limit valid |
| len_bytes | output | 13 | Prefetch byte limit |
| bound_stop | output | 1 | Current doubleword is last before a 1 MB boundary |

## Verification
The byte limit is due in the cycle after the request cycle. The bench drives a request at a falling edge and pushes the expected limit into a queue. A monitor pops and compares that limit on the next falling edge where `len_valid` is high, and it reports any `len_valid` that arrives with no pending entry.

The stop strobe is due one clock after the request or acknowledge that places the tracker on the last doubleword below a boundary. The bench therefore checks `bound_stop` at the falling edge after each such step. That includes the steps that follow tracker shutdown, so a request or acknowledge that leaves the strobe unchanged is also observed.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  typedef enum logic [1:0] {
    CMD_RD   = 2'b00,
    CMD_LINE = 2'b01,
    CMD_MULT = 2'b10,
    CMD_RSVD = 2'b11
  } rd_cmd_e;

  typedef enum logic [1:0] {
    POL_ONE  = 2'b00,
    POL_LINE = 2'b01,
    POL_TWO  = 2'b10,
    POL_FULL = 2'b11
  } pf_pol_e;

  localparam int CTRL_W    = 16;
  localparam int RD_LSB    = 8;
  localparam int LINE_LSB  = 6;
  localparam int MULT_LSB  = 4;
  localparam int MAXC_LSB  = 12;
endpackage

// File: rtl/pfl_policy_sel.sv
module pfl_policy_sel
  import pfl_pkg::*;
(
  input  logic [1:0]        cmd,
  input  logic              pref,
  input  logic [CTRL_W-1:0] ctrl,
  output pf_pol_e           pol
);
  always_comb begin
    unique case (rd_cmd_e'(cmd))
      CMD_RD:   pol = pref ? pf_pol_e'(ctrl[RD_LSB +: 2]) : POL_ONE;
      CMD_LINE: pol = pf_pol_e'(ctrl[LINE_LSB +: 2]);
      CMD_MULT: pol = pf_pol_e'(ctrl[MULT_LSB +: 2]);
      default:  pol = POL_ONE;
    endcase
  end
endmodule

// File: rtl/pfl_len_calc.sv
module pfl_len_calc
  import pfl_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CLS_W     = 8,
  parameter int BUF_BYTES = 512,
  parameter int LEN_W     = $clog2(BUF_BYTES << 3) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CLS_W-1:0]  line_dw,
  input  logic [CTRL_W-1:0] ctrl,
  input  pf_pol_e           pol,
  output logic [LEN_W-1:0]  len_next,
  output logic              len_valid,
  output logic [LEN_W-1:0]  len_bytes
);
  localparam logic [LEN_W-1:0] DW_BYTES = LEN_W'(4);
  localparam logic [LEN_W-1:0] BUF_LEN  = LEN_W'(BUF_BYTES);

  logic [LEN_W-1:0] line_b, line_off, to_end, max_b;
  logic [2:0]       maxc;

  always_comb begin
    line_b   = (line_dw == '0) ? DW_BYTES : (LEN_W'(line_dw) << 2);
    line_off = req_addr[LEN_W-1:0] & (line_b - LEN_W'(1)) & ~LEN_W'(3);
    to_end   = line_b - line_off;
    maxc     = ctrl[MAXC_LSB +: 3];
    max_b    = maxc[2] ? BUF_LEN : (BUF_LEN << maxc[1:0]);
    unique case (pol)
      POL_ONE:  len_next = DW_BYTES;
      POL_LINE: len_next = to_end;
      POL_TWO:  len_next = to_end + line_b;
      default:  len_next = max_b;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_valid <= 1'b0;
      len_bytes <= '0;
    end else begin
      len_valid <= req_valid;
      if (req_valid) len_bytes <= len_next;
    end
  end

  // R6
  len_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> len_valid);
  // R6
  len_only_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !len_valid);
  // R3
  len_dw_multiple_chk: assert property (@(posedge clk) disable iff (rst)
    len_valid |-> (len_bytes[1:0] == 2'b00 && len_bytes != '0));
  // R4
  len_cap_chk: assert property (@(posedge clk) disable iff (rst)
    len_valid |-> (len_bytes <= (BUF_LEN << 3)));
endmodule

// File: rtl/pfl_bound_track.sv
module pfl_bound_track #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 13,
  parameter int BOUND_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  len_next,
  input  logic              dw_ack,
  output logic              bound_stop
);
  localparam int DWA_W = ADDR_W - 2;
  localparam int LOW_W = BOUND_LOG2 - 2;
  localparam int REM_W = LEN_W - 1;

  logic [DWA_W-1:0] cur_q, cur_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic             act_q, act_d;

  always_comb begin
    cur_d = cur_q;
    rem_d = rem_q;
    act_d = act_q;
    if (req_valid) begin
      cur_d = req_addr[ADDR_W-1:2];
      rem_d = REM_W'(len_next >> 2);
      act_d = 1'b1;
    end else if (dw_ack && act_q) begin
      if (bound_stop || rem_q <= REM_W'(1)) begin
        act_d = 1'b0;
      end else begin
        cur_d = cur_q + DWA_W'(1);
        rem_d = rem_q - REM_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q      <= '0;
      rem_q      <= '0;
      act_q      <= 1'b0;
      bound_stop <= 1'b0;
    end else begin
      cur_q      <= cur_d;
      rem_q      <= rem_d;
      act_q      <= act_d;
      bound_stop <= act_d && (cur_d[LOW_W-1:0] == {LOW_W{1'b1}});
    end
  end

  // R7
  stop_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    bound_stop |-> (act_q && cur_q[LOW_W-1:0] == {LOW_W{1'b1}}));
  // R8
  stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (bound_stop && dw_ack && !req_valid) |=> (!bound_stop && !act_q));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!act_q && !req_valid) |=> !bound_stop);
endmodule

// File: rtl/pf_len_ctrl.sv
module pf_len_ctrl
  import pfl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CLS_W      = 8,
  parameter int BUF_BYTES  = 512,
  parameter int BOUND_LOG2 = 20,
  parameter int LEN_W      = $clog2(BUF_BYTES << 3) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_pref,
  input  logic [CLS_W-1:0]  line_dw,
  input  logic [CTRL_W-1:0] buf_ctrl,
  input  logic              dw_ack,
  output logic              len_valid,
  output logic [LEN_W-1:0]  len_bytes,
  output logic              bound_stop
);
  pf_pol_e          pol;
  logic [LEN_W-1:0] len_next;

  pfl_policy_sel u_sel (
    .cmd  (req_cmd),
    .pref (req_pref),
    .ctrl (buf_ctrl),
    .pol  (pol)
  );

  pfl_len_calc #(
    .ADDR_W(ADDR_W), .CLS_W(CLS_W), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)
  ) u_calc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .line_dw(line_dw), .ctrl(buf_ctrl), .pol(pol), .len_next(len_next),
    .len_valid(len_valid), .len_bytes(len_bytes)
  );

  pfl_bound_track #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BOUND_LOG2(BOUND_LOG2)
  ) u_trk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .len_next(len_next), .dw_ack(dw_ack), .bound_stop(bound_stop)
  );

  // R1
  nonpref_single_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cmd == 2'b00 && !req_pref) |=> (len_bytes == LEN_W'(4)));
  // R2
  rsvd_single_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cmd == 2'b11) |=> (len_bytes == LEN_W'(4)));
endmodule

// File: tb/pf_len_ctrl_test.sv
module pf_len_ctrl_test;
  logic        clk = 0;
  logic        rst;
  logic        req_valid, req_pref, dw_ack;
  logic [1:0]  req_cmd;
  logic [31:0] req_addr;
  logic [7:0]  line_dw;
  logic [15:0] buf_ctrl;
  logic        len_valid, bound_stop;
  logic [12:0] len_bytes;

  int errors = 0, checks = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    done = 0;

  always #5 clk = ~clk;

  pf_len_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_pref(req_pref), .line_dw(line_dw),
    .buf_ctrl(buf_ctrl), .dw_ack(dw_ack), .len_valid(len_valid),
    .len_bytes(len_bytes), .bound_stop(bound_stop)
  );

  function automatic int model_len(input int cmd, input int addr, input bit pref,
                                   input int cls, input int ctrl);
    int line, pol, start, n;
    line  = (cls == 0) ? 4 : cls * 4;
    start = line - ((addr % line) / 4) * 4;
    case (cmd)
      0: pol = pref ? ((ctrl / 256) % 4) : 0;
      1: pol = (ctrl / 64) % 4;
      2: pol = (ctrl / 16) % 4;
      default: pol = 0;
    endcase
    n = (ctrl / 4096) % 8;
    case (pol)
      0: return 4;
      1: return start;
      2: return start + line;
      default: return (n > 3) ? 512 : 512 * (1 << n);
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int cmd, input int addr, input bit pref,
                      input int cls, input int ctrl, input string tag);
    @(negedge clk);
    req_cmd = cmd[1:0]; req_addr = addr; req_pref = pref;
    line_dw = cls[7:0]; buf_ctrl = ctrl[15:0]; req_valid = 1;
    exp_q.push_back(model_len(cmd, addr, pref, cls, ctrl));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  // monitor: result is due one cycle after the request
  always @(negedge clk) begin
    if (!rst && len_valid) begin
      if (exp_q.size() == 0) check(0, "R6 unexpected len_valid", 1, 0);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(len_bytes) == e, t, int'(len_bytes), e);
      end
    end
  end

  task automatic stop_chk(input bit exp, input string tag);
    check(bound_stop == exp, tag, bound_stop, exp);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; req_valid = 0; dw_ack = 0; req_cmd = 0; req_addr = 0;
    req_pref = 0; line_dw = 16; buf_ctrl = 16'h0000;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(len_valid == 0, "R6 reset len_valid", len_valid, 0);
    stop_chk(0, "R7 reset bound_stop");

    send(0, 32'h1000, 0, 16, 16'h0300, "R1 nonpref plain read");
    send(0, 32'h1008, 1, 16, 16'h0100, "R3 plain line policy unaligned");
    send(1, 32'h2000, 0, 16, 16'h0040, "R1 line cmd ignores pref");
    send(1, 32'h2010, 1, 16, 16'h0080, "R3 line plus one");
    send(2, 32'h3000, 1, 16, 16'h0030, "R4 full n=0");
    send(2, 32'h3000, 1, 16, 16'h2030, "R4 full n=2");
    send(2, 32'h3000, 1, 16, 16'h5030, "R4 full n=5 saturates");
    send(2, 32'h3000, 1, 16, 16'h3030, "R4 full n=3");
    send(0, 32'h4004, 1, 16, 16'h0000, "R3 policy one dword");
    send(1, 32'h4000, 1, 0, 16'h0080, "R5 zero line size");
    send(1, 32'h400F, 1, 8, 16'h0040, "R5 low address bits ignored");
    send(3, 32'h5000, 1, 16, 16'hFFFF, "R2 reserved command");
    send(2, 32'h6008, 1, 32, 16'h0310, "R2 multiple uses own field");
    @(negedge clk);
    check(exp_q.size() == 0, "R6 all results arrived", exp_q.size(), 0);

    // boundary approach: start two dwords below 1 MB
    send(2, 32'h000FFFF8, 1, 16, 16'h0030, "R6 boundary request");
    stop_chk(0, "R7 not yet at boundary");
    dw_ack = 1;
    @(negedge clk);
    stop_chk(1, "R7 last dword before 1MB");
    @(negedge clk);
    stop_chk(0, "R8 ends after strobed ack");
    @(negedge clk);
    stop_chk(0, "R8 stays low after end");
    dw_ack = 0;

    // starting on the last dword strobes at once
    send(0, 32'h002FFFFC, 1, 16, 16'h0300, "R6 edge start request");
    stop_chk(1, "R7 start on last dword");
    dw_ack = 1;
    @(negedge clk);
    stop_chk(0, "R8 cleared after ack");
    dw_ack = 0;

    // count exhausted before boundary
    send(0, 32'h001FFFF8, 1, 16, 16'h0000, "R6 short request");
    dw_ack = 1;
    @(negedge clk);
    stop_chk(0, "R8 limit used up first");
    @(negedge clk);
    stop_chk(0, "R8 no strobe past limit");
    dw_ack = 0;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule